// File: doc/BRIEF.md
# Configurable Bidirectional Pad Bank

This block is a bank of programmable bidirectional pad cells. Every cell has three registers: one on the input path, one on the output data path and one on the output-enable path. The cell gives the fabric two views of its pad at once. One is the unregistered pad level. The other is the level captured in the input register, which samples the pad directly with no fabric logic in front of it.

On the way out, a static per-cell selector picks what drives the pad: the fabric data directly, or the output register loaded from that data. The enable is built the same way. A per-cell source selector first picks either the cell's own fabric enable or the bank-wide enable line. A second selector then uses that source either directly or through the enable register. When the resulting enable is low, the cell releases the pad to high impedance and the input path follows whatever drives the pad from outside.

The bank control pins carry the shared register clock, the bank-wide enable and an asynchronous active-high reset. All selector settings are parameter vectors, one bit per cell. They are fixed at elaboration and never change at run time. Every pin is a plain level signal. No data moves through a handshake, so there is no back-pressure: each pin is sampled on every rising edge of the bank clock.

Top module: `iob_bank`

## Requirements
- R1: `fab_din_raw[i]` shows the current level of `pad[i]` combinationally, in the same cycle, whether the pad is driven by the cell or from outside.
- R2: On a rising edge of `bank_clk` with `in_ce[i]` high, `fab_din_reg[i]` takes the level `pad[i]` had just before that edge. With `in_ce[i]` low, it holds its value.
- R3: A cell whose bit in `OUT_REG_MASK` is 0 drives `pad[i]` with `fab_dout[i]` in the same cycle while its enable is high.
- R4: A cell whose bit in `OUT_REG_MASK` is 1 drives `pad[i]` from its output register. That register loads `fab_dout[i]` on a rising edge when `out_ce[i]` is high and holds its value otherwise.
- R5: The enable source of a cell is `bank_oe` when its bit in `OE_GLOBAL_MASK` is 1, and `fab_oe[i]` when that bit is 0. The unselected signal has no effect on the pad.
- R6: A cell whose bit in `OE_REG_MASK` is 1 takes its enable from the enable register. That register loads the selected source on a rising edge when `oe_ce[i]` is high. A cell whose bit is 0 uses the selected source directly.
- R7: While a cell's effective enable is low, the cell leaves `pad[i]` at high impedance. An external level placed on the pad then appears on `fab_din_raw[i]`.
- R8: While `bank_rst` is high, all three registers of every cell are 0. As a result, `fab_din_reg` reads 0, cells with a registered enable release their pads, and cells with a registered output and a direct enable drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bank_clk | input | 1 | Shared register clock for every cell of the bank |
| bank_rst | input | 1 | Asynchronous active-high reset of all cell registers |
| bank_oe | input | 1 | Bank-wide output enable, used by cells selected in OE_GLOBAL_MASK |
| fab_dout | input | NCELLS | Data from the fabric toward each pad |
| fab_oe | input | NCELLS | Per-cell output enable from the fabric |
| in_ce | input | NCELLS | Clock enable of each input register |
| out_ce | input | NCELLS | Clock enable of each output register |
| oe_ce | input | NCELLS | Clock enable of each output-enable register |
| fab_din_raw | output | NCELLS | Unregistered pad level toward the fabric |
| fab_din_reg | output | NCELLS | Registered pad level toward the fabric |
| pad | inout | NCELLS | Bidirectional pad pins |

## Verification
The default masks give each of the eight cells a different combination of output mode, enable mode and enable source, so a single stimulus vector exercises all variants at once.

The patterns are run in this order:
- All enables off, with alternating and solid external levels. This separates the raw input view from the registered one.
- Per-cell enables on with the bank line off, then the reverse. These show which cells follow which source.
- Clock enables dropped while data, enables and external levels keep changing. This tells a holding register from one that loads.
- A long pseudo-random run, with a reset in the middle that is checked with enables high. This covers enable transitions, where the pad changes owner at a clock edge.

// File: rtl/iob_pkg.sv
package iob_pkg;

  // Static selector settings of one pad cell
  typedef struct packed {
    logic out_reg;    // 1: pad data comes from the output register
    logic oe_reg;     // 1: enable comes from the enable register
    logic oe_global;  // 1: enable source is the bank-wide line
  } cell_cfg_t;

  localparam int unsigned DEF_CELLS = 8;

endpackage

// File: rtl/iob_ff.sv
module iob_ff #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (ce) q <= d;
  end

  // R8: a register held in reset across two edges reads zero
  assert_reset_clear_R8: assert property (@(posedge clk) rst ##1 rst |-> q == '0)
    else $error("register not cleared by reset");

endmodule

// File: rtl/iob_cell.sv
module iob_cell #(
  parameter iob_pkg::cell_cfg_t CFG = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic glb_oe,
  input  logic f_dout,
  input  logic f_oe,
  input  logic ce_i,
  input  logic ce_o,
  input  logic ce_e,
  input  logic pad_in,
  output logic din_raw,
  output logic din_reg,
  output logic drv_en,
  output logic drv_val
);

  logic out_q;
  logic oe_q;
  logic oe_src;

  // Input path: the pad feeds the capture register directly
  iob_ff #(.W(1)) u_in_ff (
    .clk(clk), .rst(rst), .ce(ce_i), .d(pad_in), .q(din_reg)
  );
  assign din_raw = pad_in;

  // Output data path
  iob_ff #(.W(1)) u_out_ff (
    .clk(clk), .rst(rst), .ce(ce_o), .d(f_dout), .q(out_q)
  );

  generate
    if (CFG.out_reg) begin : g_out_registered
      assign drv_val = out_q;
    end else begin : g_out_direct
      assign drv_val = f_dout;
    end
  endgenerate

  // Enable source choice, then direct or registered use
  generate
    if (CFG.oe_global) begin : g_src_bank
      assign oe_src = glb_oe;
    end else begin : g_src_cell
      assign oe_src = f_oe;
    end
  endgenerate

  iob_ff #(.W(1)) u_oe_ff (
    .clk(clk), .rst(rst), .ce(ce_e), .d(oe_src), .q(oe_q)
  );

  generate
    if (CFG.oe_reg) begin : g_oe_registered
      assign drv_en = oe_q;
    end else begin : g_oe_direct
      assign drv_en = oe_src;
    end
  endgenerate

  // R2: capture the pad level on an enabled edge, hold otherwise
  assert_inreg_load_R2: assert property (@(posedge clk) disable iff (rst)
    ce_i |=> din_reg === $past(pad_in))
    else $error("input register missed pad level");
  assert_inreg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !ce_i |=> $stable(din_reg))
    else $error("input register changed without clock enable");

  // R4: output register loads fabric data on an enabled edge
  assert_outreg_load_R4: assert property (@(posedge clk) disable iff (rst)
    ce_o |=> out_q == $past(f_dout))
    else $error("output register missed fabric data");

  // R6: enable register loads the selected source on an enabled edge
  assert_oereg_load_R6: assert property (@(posedge clk) disable iff (rst)
    ce_e |=> oe_q == $past(oe_src))
    else $error("enable register missed its source");

endmodule

// File: rtl/iob_bank.sv
module iob_bank #(
  parameter int unsigned          NCELLS         = iob_pkg::DEF_CELLS,
  parameter logic [NCELLS-1:0]    OUT_REG_MASK   = 8'hAA,
  parameter logic [NCELLS-1:0]    OE_REG_MASK    = 8'hCC,
  parameter logic [NCELLS-1:0]    OE_GLOBAL_MASK = 8'hF0
) (
  input  logic              bank_clk,
  input  logic              bank_rst,
  input  logic              bank_oe,
  input  logic [NCELLS-1:0] fab_dout,
  input  logic [NCELLS-1:0] fab_oe,
  input  logic [NCELLS-1:0] in_ce,
  input  logic [NCELLS-1:0] out_ce,
  input  logic [NCELLS-1:0] oe_ce,
  output logic [NCELLS-1:0] fab_din_raw,
  output logic [NCELLS-1:0] fab_din_reg,
  inout  wire  [NCELLS-1:0] pad
);

  logic [NCELLS-1:0] drv_en;
  logic [NCELLS-1:0] drv_val;

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    localparam iob_pkg::cell_cfg_t CFG_I = '{
      out_reg:   OUT_REG_MASK[i],
      oe_reg:    OE_REG_MASK[i],
      oe_global: OE_GLOBAL_MASK[i]
    };

    iob_cell #(.CFG(CFG_I)) u_cell (
      .clk     (bank_clk),
      .rst     (bank_rst),
      .glb_oe  (bank_oe),
      .f_dout  (fab_dout[i]),
      .f_oe    (fab_oe[i]),
      .ce_i    (in_ce[i]),
      .ce_o    (out_ce[i]),
      .ce_e    (oe_ce[i]),
      .pad_in  (pad[i]),
      .din_raw (fab_din_raw[i]),
      .din_reg (fab_din_reg[i]),
      .drv_en  (drv_en[i]),
      .drv_val (drv_val[i])
    );

    // Tri-state pad driver
    assign pad[i] = drv_en[i] ? drv_val[i] : 1'bz;
  end

  // R1: while the bank drives a pad, the raw view returns the driven level
  assert_loopback_R1: assert property (@(posedge bank_clk) disable iff (bank_rst)
    ((fab_din_raw ^ drv_val) & drv_en) == '0)
    else $error("driven pad level not seen on raw input");

endmodule

// File: tb/iob_bank_test.sv
`timescale 1ns/1ps
module iob_bank_test;
  localparam int N = 8;
  localparam logic [N-1:0] OUTR = 8'hAA;
  localparam logic [N-1:0] OER  = 8'hCC;
  localparam logic [N-1:0] OEG  = 8'hF0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boe = 1'b0;
  logic [N-1:0] fdout = '0, foe = '0, cei = '0, ceo = '0, ceoe = '0;
  logic [N-1:0] ext_en = '0, ext_val = '0;
  wire  [N-1:0] pad;
  wire  [N-1:0] raw, rg;

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_ext
    assign pad[g] = ext_en[g] ? ext_val[g] : 1'bz;
  end

  iob_bank #(.NCELLS(N), .OUT_REG_MASK(OUTR), .OE_REG_MASK(OER), .OE_GLOBAL_MASK(OEG)) uut (
    .bank_clk(clk), .bank_rst(rst), .bank_oe(boe), .fab_dout(fdout), .fab_oe(foe),
    .in_ce(cei), .out_ce(ceo), .oe_ce(ceoe), .fab_din_raw(raw), .fab_din_reg(rg), .pad(pad)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct packed {
    logic [N-1:0] raw_v, raw_m, reg_v, reg_m, drv_m;
  } exp_t;
  exp_t sbq[$];

  logic [N-1:0] m_in = '0, m_out = '0, m_oe = '0, m_known = '0;

  function automatic logic [N-1:0] f_src(input logic [N-1:0] fo, input logic b);
    return (OEG & {N{b}}) | (~OEG & fo);            // R5
  endfunction
  function automatic logic [N-1:0] f_oe(input logic [N-1:0] q, input logic [N-1:0] fo, input logic b);
    return (OER & q) | (~OER & f_src(fo, b));       // R6
  endfunction
  function automatic logic [N-1:0] f_dv(input logic [N-1:0] q, input logic [N-1:0] d);
    return (OUTR & q) | (~OUTR & d);                // R3, R4
  endfunction

  task automatic cmp(input string req, input logic [N-1:0] act, input logic [N-1:0] exp, input logic [N-1:0] msk);
    checks++;
    if (((act ^ exp) & msk) !== '0) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b mask %b", req, $time, act, exp, msk);
    end
  endtask

  // Driver: apply one cycle of stimulus at a falling edge, push the expectation
  task automatic step(input logic [N-1:0] d, input logic [N-1:0] fo, input logic b,
                      input logic [N-1:0] ci, input logic [N-1:0] co, input logic [N-1:0] ce,
                      input logic [N-1:0] xv);
    logic [N-1:0] oe0, oe1, n_out, n_oe, n_in, n_k, xe, p0, k0, p1;
    exp_t e;
    fdout = d; foe = fo; boe = b; cei = ci; ceo = co; ceoe = ce;
    oe0   = f_oe(m_oe, fo, b);
    n_out = (co & d) | (~co & m_out);
    n_oe  = (ce & f_src(fo, b)) | (~ce & m_oe);
    oe1   = f_oe(n_oe, fo, b);
    xe    = ~oe0 & ~oe1;                            // drive only where the bank stays released
    ext_en = xe; ext_val = xv;
    p0    = (oe0 & f_dv(m_out, d)) | (~oe0 & xv);
    k0    = oe0 | xe;
    n_in  = (ci & p0) | (~ci & m_in);
    n_k   = (ci & k0) | (~ci & m_known);
    p1    = (oe1 & f_dv(n_out, d)) | (~oe1 & xv);
    e.raw_v = p1; e.raw_m = oe1 | xe; e.reg_v = n_in; e.reg_m = n_k; e.drv_m = oe1;
    sbq.push_back(e);
    m_in = n_in; m_known = n_k; m_out = n_out; m_oe = n_oe;
    @(negedge clk);
  endtask

  // Monitor: after each rising edge, compare the oldest expectation
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      cmp("R1/R7 raw input", raw, e.raw_v, e.raw_m);
      cmp("R2 registered input", rg, e.reg_v, e.reg_m);
      cmp("R3/R4/R5/R6 pad drive", pad, e.raw_v, e.drv_m);
    end
  end

  // R8: reset with enables high, checked while reset is held
  task automatic do_reset(input logic [N-1:0] d, input logic [N-1:0] xv);
    wait (sbq.size() == 0);
    @(negedge clk);
    rst = 1'b1; fdout = d; foe = '1; boe = 1'b1; cei = '1; ceo = '1; ceoe = '1;
    ext_en = OER; ext_val = xv;                     // registered-enable cells are released
    @(posedge clk); #1;
    cmp("R8 registered input zero", rg, '0, '1);
    cmp("R8 pad levels", pad, (OER & xv) | (~OER & f_dv('0, d)), '1);
    @(negedge clk);
    @(posedge clk); #1;
    cmp("R8 held reset", rg, '0, '1);
    @(negedge clk);
    m_in = '0; m_out = '0; m_oe = '0; m_known = '1;
    ext_en = '0; foe = '0; boe = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset(8'h3C, 8'h5A);
    // R1, R2, R7: all released, external patterns
    step(8'h0F, '0, 1'b0, '1, '1, '1, 8'h00);
    step(8'hF0, '0, 1'b0, '1, '1, '1, 8'hFF);
    step(8'h33, '0, 1'b0, '1, '1, '1, 8'h55);
    step(8'hCC, '0, 1'b0, '1, '1, '1, 8'hAA);
    // R3, R4, R5: per-cell enables on, bank line off
    step(8'h5A, '1, 1'b0, '1, '1, '1, 8'h0F);
    step(8'hA5, '1, 1'b0, '1, '1, '1, 8'hF0);
    step(8'hFF, '1, 1'b0, '1, '1, '1, 8'h00);
    step(8'h00, '1, 1'b0, '1, '1, '1, 8'hFF);
    // R5: bank line on, per-cell off
    step(8'h96, '0, 1'b1, '1, '1, '1, 8'h3C);
    step(8'h69, '0, 1'b1, '1, '1, '1, 8'hC3);
    step(8'h0F, '0, 1'b1, '1, '1, '1, 8'h55);
    // R2, R4, R6: clock enables low, inputs keep moving
    step(8'hF0, '1, 1'b1, '0, '0, '0, 8'hAA);
    step(8'h0F, '0, 1'b0, '0, '0, '0, 8'h55);
    step(8'hFF, '1, 1'b0, '0, '0, '0, 8'hFF);
    step(8'h00, '0, 1'b1, '1, '0, '1, 8'h00);
    // Mixed pseudo-random run
    for (int k = 0; k < 300; k++) begin
      step(N'($urandom), N'($urandom), 1'($urandom), N'($urandom), N'($urandom),
           N'($urandom), N'($urandom));
    end
    do_reset(8'hC3, 8'hA5);
    for (int k = 0; k < 100; k++) begin
      step(N'($urandom), N'($urandom), 1'($urandom), '1, N'($urandom), N'($urandom), N'($urandom));
    end
    wait (sbq.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule